// File: doc/BRIEF.md
# Status Byte Service Request Generator

This block assembles an instrument-style status byte from six summary signals that lower-level status registers and queues produce: extended-status summary, trace-status summary, error queue not empty, questionable-status summary, message available and event-status summary. Next to the byte sits a service request enable mask. Bit 6 of the byte is computed as a master summary. It is set whenever any of the six live status bits is set together with its enable bit.

A service request is raised only when an enabled status bit goes from 0 to 1. A bit that stays high raises nothing further. Setting an enable bit while its status bit is already high raises nothing either. Each request appears as a one-cycle pulse and also sets a sticky flag, which stays set until the host clears it. A small register port, with one select bit and a combinational read path, lets the host read the status byte and write and read back the enable mask.

Top module: `statusByteSrq`

## Requirements
- R1: With `regSel` = 0, `regRdData` bits 0..5 equal `sumIn[0..5]` in the same cycle. The bit order is extended summary (0), trace summary (1), error queue not empty (2), questionable summary (3), message available (4) and event-status summary (5). Bit 7 reads 0.
- R2: With `regSel` = 0, `regRdData[6]` is 1 exactly when some bit i in 0..5 has both `sumIn[i]` and enable bit i set.
- R3: A write with `regWrEn` = 1 and `regSel` = 1 stores `regWrData[6:0]` at the clock edge. From the next cycle, a read with `regSel` = 1 returns those seven bits, with bit 7 reading 0.
- R4: Enable bit 6 affects neither the master summary nor the service request logic.
- R5: When an enabled bit of `sumIn[5:0]` is 1 in a cycle and was 0 in the previous cycle, `srqPulse` is 1 for exactly the following cycle.
- R6: A status bit that stays at 1 raises no request. Setting its enable bit while it is already 1 raises none either.
- R7: `srqFlag` is set in the same cycle as `srqPulse` and holds until a cycle with `srqClear` = 1, after which it reads 0. If a new request arrives in the clear cycle, the request wins.
- R8: After reset the enable mask, the edge history, `srqPulse` and `srqFlag` are all 0.
- R9: A write with `regSel` = 0 leaves the enable mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sumIn | input | 6 | Live summary inputs, status bits 0..5 |
| regSel | input | 1 | Register select: 0 status byte, 1 enable mask |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for the selected register |
| srqClear | input | 1 | Clears the sticky request flag |
| srqPulse | output | 1 | One-cycle service request |
| srqFlag | output | 1 | Sticky service request flag |

## Verification
A corrupted edge-history bit shows up within one cycle: either a missing `srqPulse` after an enabled rise, or a false pulse while a level holds steady. A wrong enable bit shows up in the master summary on the very next read of the status byte, and in the mask readback. The sticky flag is compared every cycle, so a lost set or a lost clear is reported one cycle after the edge that should have changed it.

// File: rtl/sbsrq_pkg.sv
package sbsrq_pkg;
  localparam int SUM_W  = 6;
  localparam int BYTE_W = 8;
  localparam int MSS_BIT = SUM_W;
  localparam int EN_W = SUM_W + 1;

  typedef struct packed {
    logic wrEnable;
    logic clrFlag;
    logic rdEnable;
  } ctlStrobe_t;
endpackage

// File: rtl/sbsrqCtrl.sv
module sbsrqCtrl
  import sbsrq_pkg::*;
(
  input  logic       regSel,
  input  logic       regWrEn,
  input  logic       srqClear,
  output ctlStrobe_t strobe
);
  always_comb begin
    strobe.wrEnable = regWrEn && regSel;
    strobe.clrFlag  = srqClear;
    strobe.rdEnable = regSel;
  end
endmodule

// File: rtl/sbsrqDatapath.sv
module sbsrqDatapath
  import sbsrq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SUM_W-1:0]  sumIn,
  input  logic [BYTE_W-1:0] regWrData,
  input  ctlStrobe_t        strobe,
  output logic [BYTE_W-1:0] regRdData,
  output logic              srqPulse,
  output logic              srqFlag
);
  logic [EN_W-1:0]  enQ;
  logic [SUM_W-1:0] prevQ;
  logic [SUM_W-1:0] riseVec;
  logic [SUM_W-1:0] hitVec;
  logic             mss;
  logic             reqNow;

  // per-bit edge and mask gating
  for (genvar i = 0; i < SUM_W; i++) begin : g_bit
    assign riseVec[i] = sumIn[i] & ~prevQ[i] & enQ[i];
    assign hitVec[i]  = sumIn[i] & enQ[i];
  end

  assign mss    = |hitVec;
  assign reqNow = |riseVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ      <= '0;
      prevQ    <= '0;
      srqPulse <= 1'b0;
      srqFlag  <= 1'b0;
    end else begin
      prevQ    <= sumIn;
      srqPulse <= reqNow;
      if (strobe.wrEnable) enQ <= regWrData[EN_W-1:0];
      if (reqNow)              srqFlag <= 1'b1;
      else if (strobe.clrFlag) srqFlag <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    if (strobe.rdEnable) regRdData[EN_W-1:0] = enQ;
    else                 regRdData = {1'b0, mss, sumIn};
  end

  AST_FLAG_ON_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    srqPulse |-> srqFlag); // R7
  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.clrFlag) && !srqPulse) |-> !srqFlag); // R7
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.wrEnable) |-> $stable(enQ)); // R9
  AST_NO_SRQ_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    srqPulse |-> ($past(sumIn) != $past(sumIn, 2))); // R6
  AST_BIT7_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[BYTE_W-1] == 1'b0); // R1
endmodule

// File: rtl/statusByteSrq.sv
module statusByteSrq
  import sbsrq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SUM_W-1:0]  sumIn,
  input  logic              regSel,
  input  logic              regWrEn,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  input  logic              srqClear,
  output logic              srqPulse,
  output logic              srqFlag
);
  ctlStrobe_t strobe;

  sbsrqCtrl u_ctrl (
    .regSel   (regSel),
    .regWrEn  (regWrEn),
    .srqClear (srqClear),
    .strobe   (strobe)
  );

  sbsrqDatapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sumIn     (sumIn),
    .regWrData (regWrData),
    .strobe    (strobe),
    .regRdData (regRdData),
    .srqPulse  (srqPulse),
    .srqFlag   (srqFlag)
  );
endmodule

// File: tb/statusByteSrq_bench.sv
module statusByteSrq_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] sumIn = '0;
  logic       regSel = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       srqClear = 1'b0;
  logic       srqPulse;
  logic       srqFlag;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  logic [6:0] mEn;
  logic [5:0] mPrev;
  logic       mPulse, mFlag;

  always #10 clk = ~clk;

  statusByteSrq u_statusByteSrq (
    .clk(clk), .rstN(rstN), .sumIn(sumIn), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .srqClear(srqClear),
    .srqPulse(srqPulse), .srqFlag(srqFlag)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] expRd(input logic sel, input logic [5:0] s, input logic [6:0] en);
    if (sel) return {1'b0, en};
    return {1'b0, |(s & en[5:0]), s};
  endfunction

  // one cycle: drive at negedge, advance model, compare at next negedge
  task automatic step(input logic [5:0] s, input logic wr, input logic sel,
                      input logic [7:0] d, input logic clr, input string tag);
    logic nPulse;
    sumIn = s; regWrEn = wr; regSel = sel; regWrData = d; srqClear = clr;
    nPulse = |(s & ~mPrev & mEn[5:0]);
    mFlag  = nPulse ? 1'b1 : (clr ? 1'b0 : mFlag);
    mPulse = nPulse;
    mPrev  = s;
    if (wr && sel) mEn = d[6:0];
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R5 pulse"}, {7'b0, srqPulse}, {7'b0, mPulse});
    chk({tag, " R7 flag"}, {7'b0, srqFlag}, {7'b0, mFlag});
    chk({tag, sel ? " R3 enable read" : " R1 R2 status read"}, regRdData, expRd(sel, s, mEn));
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    mEn = '0; mPrev = '0; mPulse = 0; mFlag = 0;
    sumIn = 6'h3F;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R8: reset state; inputs were high during reset but mask is clear
    chk("R8 pulse", {7'b0, srqPulse}, 8'h0);
    chk("R8 flag", {7'b0, srqFlag}, 8'h0);
    regSel = 1'b1; #1;
    chk("R8 enable", regRdData, 8'h00);
    @(negedge clk);
    mPrev = 6'h3F;

    // R8: history cleared, so bits high from reset count as rises once enabled? mask 0 => none
    step(6'h00, 1, 1, 8'hFF, 0, "R3");   // bit7 of write dropped
    step(6'h00, 0, 1, 8'h00, 0, "R3");
    // R9: write to status address ignored
    step(6'h00, 1, 0, 8'h00, 0, "R9");
    step(6'h00, 0, 1, 8'h00, 0, "R9");
    // R4: only bit 6 enabled -> no mss, no request
    step(6'h00, 1, 1, 8'h40, 0, "R4");
    step(6'h3F, 0, 0, 8'h00, 0, "R4");
    step(6'h3F, 0, 0, 8'h00, 0, "R4");
    // R6: enable while already high -> no request
    step(6'h3F, 1, 1, 8'h04, 0, "R6");
    step(6'h3F, 0, 0, 8'h00, 0, "R6");
    step(6'h3F, 0, 0, 8'h00, 0, "R6");
    // R5: rise on enabled bit 2 (error queue)
    step(6'h3B, 0, 0, 8'h00, 0, "R5");
    step(6'h3F, 0, 0, 8'h00, 0, "R5");
    step(6'h3F, 0, 0, 8'h00, 0, "R5");
    // R7: clear
    step(6'h3F, 0, 0, 8'h00, 1, "R7");
    step(6'h3B, 0, 0, 8'h00, 0, "R7");
    // R7: rise in clear cycle -> request wins
    step(6'h3F, 0, 0, 8'h00, 1, "R7");
    step(6'h3F, 0, 1, 8'h00, 0, "R7");

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] s;
      logic wr, sel, clr;
      logic [7:0] d;
      s = $urandom() % 2 ? sumIn ^ (6'd1 << ($urandom() % 6)) : sumIn;
      wr = ($urandom() % 8) == 0;
      sel = $urandom() % 2;
      d = $urandom();
      clr = ($urandom() % 6) == 0;
      step(s, wr, sel, d, clr, "RND");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule